// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block computes, inline with the data path, the single-error-correcting parity code for NAND page data. Every byte that passes with its valid strobe high is folded into two 11-bit parity words in the same clock. Within a 256-byte chunk each data bit has an 11-bit address: the byte index forms the upper eight bits and the bit position within the byte forms the lower three. The "set" word collects, for every address bit k, the XOR of all data bits whose address has bit k high. The "clear" word collects the same XOR over the data bits whose address has bit k low.

In 256-byte mode only one chunk is coded, and bytes beyond it are dropped. In 512-byte mode the second 256 bytes build an independent pair of words. Software packs a chunk's code as the set word in bits 10:0 and the clear word in bits 21:11, then stores it as three little-endian bytes. A clear request empties both pairs and the byte counter. The busy flag reads high while the clear is in progress.

Top module: `nand_parity_gen`

## Requirements
- R1: After reset all four parity words are zero and `clr_busy` is low.
- R2: For the first chunk, `set0` bit k equals the XOR of every accepted data bit whose address {byte index[7:0], bit index[2:0]} has bit k = 1. `clr0` bit k is the same XOR over addresses with bit k = 0.
- R3: One byte is accepted per clock while `din_vld` is high. Its effect on the parity words is visible at the clock edge that samples it.
- R4: With `page512` low, only the first 256 accepted bytes count. Later bytes change no word until the next clear, and `set1`/`clr1` stay zero.
- R5: With `page512` high, bytes 0 to 255 build `set0`/`clr0`, and bytes 256 to 511 build `set1`/`clr1` under the same address rule, using the byte index within the second chunk.
- R6: With `page512` high, bytes beyond the 512th are ignored until the next clear.
- R7: Sampling `clr_req` high raises `clr_busy` for exactly one cycle. When `clr_busy` falls, all four words are zero and the next accepted byte counts as byte 0.
- R8: A byte presented while `clr_req` or `clr_busy` is high is ignored.
- R9: When `din_vld` is low, the value on `din` has no effect on any parity word.
- R10: Within each chunk the set and clear words are bitwise complementary or identical, because every byte adds its overall parity to one of the two words at every address bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page512 | input | 1 | 1 selects 512-byte pages (two chunks), 0 selects 256-byte pages |
| din_vld | input | 1 | Byte strobe |
| din | input | 8 | Data byte |
| clr_req | input | 1 | Pulse that requests an accumulator clear |
| clr_busy | output | 1 | High while the clear is in progress |
| set0 | output | 11 | Set-group parity, first chunk |
| clr0 | output | 11 | Clear-group parity, first chunk |
| set1 | output | 11 | Set-group parity, second chunk |
| clr1 | output | 11 | Clear-group parity, second chunk |

## Verification
Each byte's contribution is due at the rising edge that samples it. The bench drives on falling edges and compares at the next falling edge, so each check falls half a cycle after the register update. A clear shows `clr_busy` high one edge after the request and low with all-zero words one edge later, and the bench samples at both of those falling edges. Expected words come from a bench function that recomputes both pairs from the list of bytes the requirements say were accepted.

// File: rtl/nand_parity_gen.sv
module nand_parity_gen #(
  parameter int BYTE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               page512,
  input  logic               din_vld,
  input  logic [7:0]         din,
  input  logic               clr_req,
  output logic               clr_busy,
  output logic [BYTE_AW+2:0] set0,
  output logic [BYTE_AW+2:0] clr0,
  output logic [BYTE_AW+2:0] set1,
  output logic [BYTE_AW+2:0] clr1
);
  localparam int PW = BYTE_AW + 3;

  logic [BYTE_AW:0] idx;
  logic             full;
  logic [PW-1:0]    s0, c0, s1, c1;
  logic [PW-1:0]    add_s, add_c;

  wire second = idx[BYTE_AW];
  wire take   = din_vld & ~clr_busy & ~clr_req & ~full & (page512 | ~second);
  wire par    = ^din;

  always_comb begin
    add_s = '0;
    add_c = '0;
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < 8; b++)
        if (((b >> k) & 1) == 1) add_s[k] = add_s[k] ^ din[b];
        else                     add_c[k] = add_c[k] ^ din[b];
    for (int k = 3; k < PW; k++) begin
      add_s[k] = idx[k-3] & par;
      add_c[k] = ~idx[k-3] & par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_busy <= 1'b0;
      idx <= '0;
      full <= 1'b0;
      s0 <= '0; c0 <= '0; s1 <= '0; c1 <= '0;
    end else if (clr_busy) begin
      clr_busy <= 1'b0;
      idx <= '0;
      full <= 1'b0;
      s0 <= '0; c0 <= '0; s1 <= '0; c1 <= '0;
    end else begin
      if (clr_req) clr_busy <= 1'b1;
      if (take) begin
        idx <= idx + 1'b1;
        if (&idx) full <= 1'b1;
        if (!second) begin
          s0 <= s0 ^ add_s;
          c0 <= c0 ^ add_c;
        end else begin
          s1 <= s1 ^ add_s;
          c1 <= c1 ^ add_c;
        end
      end
    end
  end

  assign set0 = s0;
  assign clr0 = c0;
  assign set1 = s1;
  assign clr1 = c1;

  a_r7_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> !clr_busy);
  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> (set0 == '0 && clr0 == '0 && set1 == '0 && clr1 == '0));
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!din_vld && !clr_busy) |=> ($stable(set0) && $stable(clr0) && $stable(set1) && $stable(clr1)));
  a_r4_second_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!page512 && set1 == '0 && clr1 == '0) |=> (set1 == '0 && clr1 == '0));
  a_r10_pair0_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    ((set0 ^ clr0) == '0 || (set0 ^ clr0) == '1));
  a_r10_pair1_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    ((set1 ^ clr1) == '0 || (set1 ^ clr1) == '1));
endmodule

// File: tb/sim_nand_parity_gen.sv
module sim_nand_parity_gen;
  logic clk = 1'b0, rst_n = 1'b0, page512 = 1'b0, din_vld = 1'b0, clr_req = 1'b0;
  logic [7:0] din = 8'h00;
  logic clr_busy;
  logic [10:0] set0, clr0, set1, clr1;
  int n_chk = 0, n_bad = 0, cnt = 0, limit = 256;
  logic [7:0] pg [512];

  always #5 clk = ~clk;

  nand_parity_gen u0 (.clk(clk), .rst_n(rst_n), .page512(page512), .din_vld(din_vld),
    .din(din), .clr_req(clr_req), .clr_busy(clr_busy), .set0(set0), .clr0(clr0),
    .set1(set1), .clr1(clr1));

  function automatic logic [21:0] ref_code(int base, int n);
    logic [10:0] s = '0, c = '0;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic [10:0] a = {i[7:0], b[2:0]};
        for (int k = 0; k < 11; k++)
          if (a[k]) s[k] = s[k] ^ pg[base+i][b];
          else      c[k] = c[k] ^ pg[base+i][b];
      end
    return {c, s};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    int n0 = (cnt < 256) ? cnt : 256;
    int n1 = (cnt > 256) ? cnt - 256 : 0;
    check(req, {10'd0, clr0, set0}, {10'd0, ref_code(0, n0)});
    check(req, {10'd0, clr1, set1}, {10'd0, ref_code(256, n1)});
  endtask

  task automatic send(logic [7:0] d);
    din_vld = 1'b1;
    din = d;
    if (cnt < limit) begin
      pg[cnt] = d;
      cnt++;
    end
    @(negedge clk);
    din_vld = 1'b0;
    din = 8'($urandom);
  endtask

  task automatic idle_gap();
    if ($urandom % 4 == 0) begin
      din = 8'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic do_clear();
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    check("R7 busy high", {31'd0, clr_busy}, 32'd1);
    @(negedge clk);
    check("R7 busy low", {31'd0, clr_busy}, 32'd0);
    cnt = 0;
    check_all("R7 cleared");
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, clr_busy}, 32'd0);
    check_all("R1 zero words");
    rst_n = 1'b1;
    @(negedge clk);
    do_clear();

    // R2 directed corners: byte 0 bit 0 -> address 0, byte 255 bit 7 -> all ones
    send(8'h01);
    check("R2 addr0 set", {21'd0, set0}, 32'h000);
    check("R2 addr0 clr", {21'd0, clr0}, 32'h7FF);
    for (int i = 1; i < 255; i++) send(8'h00);
    send(8'h80);
    check_all("R2 last bit");
    do_clear();

    // R3/R9: 256-byte random page with gaps carrying junk on din
    limit = 256;
    page512 = 1'b0;
    for (int i = 0; i < 256; i++) begin
      idle_gap();
      send(8'($urandom));
      if (i % 37 == 0) check_all("R3 per byte");
    end
    check_all("R2 R9 full chunk");
    // R4 extra bytes in 256 mode
    for (int i = 0; i < 12; i++) send(8'($urandom));
    check_all("R4 extra ignored");
    check("R4 second pair zero", {10'd0, clr1, set1}, 32'd0);
    do_clear();

    // R5/R6: 512-byte page
    limit = 512;
    page512 = 1'b1;
    for (int i = 0; i < 512; i++) begin
      idle_gap();
      send(8'($urandom));
      if (i == 255) check_all("R5 first chunk done");
      if (i == 300) check_all("R5 second chunk partial");
    end
    check_all("R5 both chunks");
    for (int i = 0; i < 9; i++) send(8'($urandom));
    check_all("R6 extra ignored");

    // R8: bytes during request and busy cycles are dropped
    clr_req = 1'b1;
    din_vld = 1'b1;
    din = 8'hFF;
    @(negedge clk);
    clr_req = 1'b0;
    din = 8'h5A;
    check("R8 busy", {31'd0, clr_busy}, 32'd1);
    @(negedge clk);
    din_vld = 1'b0;
    cnt = 0;
    check_all("R8 ignored during clear");
    send(8'h01);
    check("R7 restart index", {10'd0, clr0, set0}, {10'd0, 11'h7FF, 11'h000});

    // R5 directed: first byte of second chunk lands at chunk index 0
    do_clear();
    for (int i = 0; i < 256; i++) send(8'h00);
    send(8'h02);
    check("R5 chunk1 index0", {10'd0, clr1, set1}, {10'd0, 11'h7FE, 11'h001});
    finish_run();
  end
endmodule